// File: doc/BRIEF.md
# Consecutive-Cycle Fault Qualifier

This block filters the protection events of a switching power converter controller so that a single noisy comparator flag cannot shut the converter down. It watches two analog comparator outputs, already resolved to logic levels, and declares a fault only when the event comes back in successive switching cycles. The converter's cycle-start pulse marks each cycle boundary. A level that is high while the power switch is off marks the off-time.

The overvoltage channel takes at most one sample per switching cycle. The sample is a window of `STROBE_CLKS` clocks that opens when the switch turns off. The channel counts cycles whose sample was high, and it latches a fault when that count reaches `OVP_CONFIRM` without a break. The second-level overcurrent channel is a three-state machine. A first trip raises a warning. A trip in the following cycle sets a shutdown latch that turns the switch off. A quiet following cycle sends the machine back to idle. Only the supply-undervoltage flag or reset clears the shutdown latch.

Top module: `fault_qualifier`

## Requirements
- R1: Driving `rst_n` low clears `ovp_cnt`, `ovp_fault`, `ovp_sample`, `ocp2_warn` and `ocp2_shutdown` to 0 at once, without waiting for a clock edge. Reset is released synchronously to `clk`.
- R2: A cycle's overvoltage sample is a hit only when two conditions hold. First, `sw_off` stays high for `STROBE_CLKS` consecutive clocks, counting from its rising edge. Second, `ovp_cmp` is high on every one of those clocks. `ovp_sample` shows the result from the clock after the window ends until the next `cycle_start`. A window cut short by `sw_off` falling gives no hit. Values of `ovp_cmp` after the window are ignored.
- R3: Only the first rising edge of `sw_off` in a cycle opens a window. Later off-time edges in the same cycle are ignored, even if the first window was cut short.
- R4: On each `cycle_start` clock, `ovp_cnt` goes up by one if the sample of the cycle just ended was a hit, and goes to 0 if it was not. It changes at no other time.
- R5: When `ovp_cnt` reaches `OVP_CONFIRM` (default 4), `ovp_fault` goes to 1. From then on `ovp_cnt` stays at `OVP_CONFIRM` and `ovp_fault` stays at 1 until reset. `uvlo` has no effect on either.
- R6: An `ocp2_cmp` high while the overcurrent channel is idle raises `ocp2_warn` one clock later and leaves `ocp2_shutdown` low. Further trips within the same cycle change nothing.
- R7: If the cycle after the one that raised the warning has no `ocp2_cmp` trip, `ocp2_warn` falls on the `cycle_start` clock that ends that quiet cycle.
- R8: An `ocp2_cmp` trip in the cycle after the warning cycle sets `ocp2_shutdown` and clears `ocp2_warn` one clock later. `ocp2_warn` and `ocp2_shutdown` are never high together.
- R9: `ocp2_shutdown` holds through any number of cycles and trips until `uvlo` is high for a clock. `uvlo` then returns the overcurrent channel to idle, with both outputs low, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cycle_start | input | 1 | One-clock pulse at the start of each switching cycle |
| sw_off | input | 1 | High while the power switch is off |
| ovp_cmp | input | 1 | Overvoltage comparator level |
| ocp2_cmp | input | 1 | Second-level overcurrent comparator level |
| uvlo | input | 1 | Supply undervoltage flag |
| ovp_fault | output | 1 | Confirmed overvoltage fault, latched |
| ovp_cnt | output | $clog2(OVP_CONFIRM+1) | Consecutive overvoltage cycle count (debug) |
| ovp_sample | output | 1 | Strobed overvoltage result of the current cycle (debug) |
| ocp2_warn | output | 1 | Overcurrent warning state |
| ocp2_shutdown | output | 1 | Overcurrent shutdown latch, turns the switch off |

## Verification
The results fall due at different clocks after their stimulus. `ocp2_warn` and `ocp2_shutdown` change on the edge that samples the trip or the `uvlo` clock. `ovp_cnt`, `ovp_fault` and the return of the warning to idle change on the edge that samples `cycle_start`. `ovp_sample` settles on the clock after the last window clock. To respect this, the bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge. It updates its cycle-level model for exactly the edge it has just crossed. It ends each off-time with one idle clock so that the sample result is in place before it is compared and before the next boundary consumes it.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef enum logic [1:0] {
    OCP_IDLE = 2'd0,
    OCP_WARN = 2'd1,
    OCP_SHUT = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/fq_strobe.sv
// Off-time sampling window: one window per switching cycle.
module fq_strobe #(
  parameter int STROBE_CLKS = 275
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic sw_off,
  input  logic ovp_cmp,
  output logic sample_hit
);
  localparam int SW = $clog2(STROBE_CLKS + 1);
  localparam logic [SW-1:0] WIN_LAST = SW'(STROBE_CLKS);

  logic          off_q, off_d;
  logic          taken_q, taken_d;
  logic [SW-1:0] win_q, win_d;
  logic          ok_q, ok_d;
  logic          hit_q, hit_d;
  logic          off_rise;

  assign off_rise = sw_off & ~off_q;

  always_comb begin
    off_d   = sw_off;
    taken_d = taken_q;
    win_d   = win_q;
    ok_d    = ok_q;
    hit_d   = hit_q;
    if (cycle_start) begin
      taken_d = 1'b0;
      win_d   = '0;
      ok_d    = 1'b0;
      hit_d   = 1'b0;
    end else if (win_q == WIN_LAST) begin
      hit_d = ok_q;
      win_d = '0;
    end else if (win_q != '0) begin
      if (sw_off) begin
        win_d = win_q + SW'(1);
        ok_d  = ok_q & ovp_cmp;
      end else begin
        win_d = '0;
        ok_d  = 1'b0;
      end
    end else if (off_rise && !taken_q) begin
      taken_d = 1'b1;
      win_d   = SW'(1);
      ok_d    = ovp_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= 1'b0;
      taken_q <= 1'b0;
      win_q   <= '0;
      ok_q    <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      off_q   <= off_d;
      taken_q <= taken_d;
      win_q   <= win_d;
      ok_q    <= ok_d;
      hit_q   <= hit_d;
    end
  end

  assign sample_hit = hit_q;

  AST_HIT_NEEDS_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> ($past(win_q) == WIN_LAST && $past(ok_q))); // R2
  AST_HIT_CLEARED_AT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !hit_q); // R2
  AST_SINGLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && win_q == '0 && !cycle_start) |=> win_q == '0); // R3
endmodule

// File: rtl/fq_ovp_count.sv
// Consecutive-cycle counter for the overvoltage channel.
module fq_ovp_count #(
  parameter int OVP_CONFIRM = 4,
  localparam int CW = $clog2(OVP_CONFIRM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_start,
  input  logic          sample_hit,
  output logic [CW-1:0] cnt,
  output logic          fault
);
  localparam logic [CW-1:0] CNT_TOP = CW'(OVP_CONFIRM);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;
  logic          cnt_en;

  assign cnt_en = cycle_start & ~fault_q;

  always_comb begin
    cnt_d   = cnt_q;
    fault_d = fault_q;
    if (cnt_en) begin
      if (sample_hit) begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CNT_TOP - CW'(1)) fault_d = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign cnt   = cnt_q;
  assign fault = fault_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R4
  AST_CNT_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !sample_hit && !fault_q) |=> cnt_q == '0); // R4
  AST_CNT_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(cnt_q)); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> (fault_q && cnt_q == CNT_TOP)); // R5
endmodule

// File: rtl/fq_ocp2_fsm.sv
// Warning / shutdown state machine for the second-level overcurrent channel.
module fq_ocp2_fsm
  import fq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic ocp2_cmp,
  input  logic uvlo,
  output logic warn,
  output logic shut
);
  ocp_state_e state_q, state_d;
  logic       cur_q, cur_d;   // a trip has occurred in the current cycle

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    if (uvlo) begin
      state_d = OCP_IDLE;
      cur_d   = 1'b0;
    end else if (cycle_start) begin
      if (state_q == OCP_WARN && !cur_q) state_d = OCP_IDLE;
      cur_d = 1'b0;
    end else begin
      unique case (state_q)
        OCP_IDLE: if (ocp2_cmp) begin
          state_d = OCP_WARN;
          cur_d   = 1'b1;
        end
        OCP_WARN: if (ocp2_cmp && !cur_q) state_d = OCP_SHUT;
        OCP_SHUT: state_d = OCP_SHUT;
        default:  state_d = OCP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OCP_IDLE;
      cur_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  assign warn = (state_q == OCP_WARN);
  assign shut = (state_q == OCP_SHUT);

  AST_WARN_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn) |-> $past(ocp2_cmp)); // R6
  AST_SHUT_FROM_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut) |-> ($past(warn) && $past(ocp2_cmp))); // R8
  AST_STATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warn, shut})); // R8
  AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && !uvlo) |=> shut); // R9
  AST_UVLO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!warn && !shut)); // R9
endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int STROBE_CLKS = 275,
  parameter int OVP_CONFIRM = 4,
  localparam int CW = $clog2(OVP_CONFIRM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_start,
  input  logic          sw_off,
  input  logic          ovp_cmp,
  input  logic          ocp2_cmp,
  input  logic          uvlo,
  output logic          ovp_fault,
  output logic [CW-1:0] ovp_cnt,
  output logic          ovp_sample,
  output logic          ocp2_warn,
  output logic          ocp2_shutdown
);
  logic hit;

  fq_strobe #(.STROBE_CLKS(STROBE_CLKS)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .sw_off     (sw_off),
    .ovp_cmp    (ovp_cmp),
    .sample_hit (hit)
  );

  fq_ovp_count #(.OVP_CONFIRM(OVP_CONFIRM)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .sample_hit (hit),
    .cnt        (ovp_cnt),
    .fault      (ovp_fault)
  );

  fq_ocp2_fsm u_ocp2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .ocp2_cmp   (ocp2_cmp),
    .uvlo       (uvlo),
    .warn       (ocp2_warn),
    .shut       (ocp2_shutdown)
  );

  assign ovp_sample = hit;

  AST_FAULT_IMPLIES_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_fault |-> ovp_cnt == CW'(OVP_CONFIRM)); // R5
endmodule

// File: tb/tb_fault_qualifier.sv
`timescale 1ns/1ps
module tb_fault_qualifier;
  localparam int S    = 6;
  localparam int CONF = 4;
  localparam int CW   = $clog2(CONF + 1);

  logic clk = 1'b0;
  logic rst_n, cycle_start, sw_off, ovp_cmp, ocp2_cmp, uvlo;
  logic ovp_fault, ovp_sample, ocp2_warn, ocp2_shutdown;
  logic [CW-1:0] ovp_cnt;

  fault_qualifier #(.STROBE_CLKS(S), .OVP_CONFIRM(CONF)) dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .sw_off(sw_off),
    .ovp_cmp(ovp_cmp), .ocp2_cmp(ocp2_cmp), .uvlo(uvlo),
    .ovp_fault(ovp_fault), .ovp_cnt(ovp_cnt), .ovp_sample(ovp_sample),
    .ocp2_warn(ocp2_warn), .ocp2_shutdown(ocp2_shutdown)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // cycle-level reference model
  int m_cnt, m_fault, m_hit, m_state, m_cur;  // m_state: 0 idle, 1 warn, 2 shut

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    m_cnt = 0; m_fault = 0; m_hit = 0; m_state = 0; m_cur = 0;
  endtask

  function automatic bit exp_hit(int off_len, int glitch, bit lvl, bit blip);
    return lvl && !blip && off_len >= S && (glitch < 0 || glitch >= S);
  endfunction

  task automatic check_ocp(string req);
    check({req, " warn"}, ocp2_warn, m_state == 1);
    check({req, " shutdown"}, ocp2_shutdown, m_state == 2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #2;
    model_reset();
    check("R1 async cnt", ovp_cnt, 0);
    check("R1 async fault", ovp_fault, 0);
    check("R1 async sample", ovp_sample, 0);
    check_ocp("R1 async");
    tick();
    rst_n = 1'b1;
  endtask

  task automatic do_cycle(int off_len, int glitch, bit lvl, int ntrips, bit blip);
    cycle_start = 1'b1; sw_off = 1'b0; ovp_cmp = 1'b0; ocp2_cmp = 1'b0;
    tick();
    if (!m_fault) begin
      if (m_hit) begin
        m_cnt++;
        if (m_cnt == CONF) m_fault = 1;
      end else m_cnt = 0;
    end
    m_hit = 0;
    if (m_state == 1 && !m_cur) m_state = 0;
    m_cur = 0;
    check("R4 count at boundary", ovp_cnt, m_cnt);
    check("R5 fault", ovp_fault, m_fault);
    check_ocp("R7 boundary");
    cycle_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      ocp2_cmp = (ntrips >= 1 && k == 1) || (ntrips >= 2 && k == 3);
      tick();
      if (ocp2_cmp) begin
        if (m_state == 0) begin m_state = 1; m_cur = 1; end
        else if (m_state == 1 && !m_cur) m_state = 2;
        check_ocp("R6/R8 trip");
      end
    end
    ocp2_cmp = 1'b0;
    if (blip) begin
      sw_off = 1'b1; ovp_cmp = lvl; tick();
      sw_off = 1'b0; tick();
    end
    for (int i = 0; i < off_len; i++) begin
      sw_off = 1'b1;
      ovp_cmp = lvl && (i != glitch);
      tick();
    end
    sw_off = 1'b0; ovp_cmp = 1'b1;  // level outside any window: ignored
    tick();
    ovp_cmp = 1'b0;
    m_hit = exp_hit(off_len, glitch, lvl, blip);
    check(blip ? "R3 one window per cycle" : "R2 strobe sample", ovp_sample, m_hit);
  endtask

  task automatic do_uvlo();
    uvlo = 1'b1;
    tick();
    uvlo = 1'b0;
    m_state = 0; m_cur = 0;
    check_ocp("R9 uvlo clear");
    check("R5 uvlo ignored cnt", ovp_cnt, m_cnt);
    check("R5 uvlo ignored fault", ovp_fault, m_fault);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b1; cycle_start = 0; sw_off = 0; ovp_cmp = 0; ocp2_cmp = 0; uvlo = 0;
    model_reset();
    #3;
    do_reset();
    tick();
    check("R1 reset cnt", ovp_cnt, 0);
    check_ocp("R1 reset");

    // R4: three hits then a glitch inside the window resets the count
    repeat (3) do_cycle(S, -1, 1, 0, 0);
    do_cycle(S, 2, 1, 0, 0);
    do_cycle(S, -1, 1, 0, 0);
    check("R4 count zero after miss", ovp_cnt, 0);
    // R2: short off-time, glitch past the window
    do_cycle(S - 1, -1, 1, 0, 0);
    do_cycle(S + 2, S, 1, 0, 0);
    // R3: aborted first window blocks a second one
    do_cycle(S + 1, -1, 1, 0, 1);
    // R5: four consecutive hits
    repeat (4) do_cycle(S, -1, 1, 0, 0);
    do_cycle(S, -1, 0, 0, 0);
    check("R5 fault latched", ovp_fault, 1);
    do_cycle(S, -1, 0, 0, 0);
    check("R5 count held", ovp_cnt, CONF);
    do_uvlo();

    // R6/R7: warning then quiet cycle
    do_cycle(S, -1, 0, 1, 0);
    do_cycle(S, -1, 0, 0, 0);
    do_cycle(S, -1, 0, 0, 0);
    check("R7 back to idle", ocp2_warn, 0);
    // R6: two trips in one cycle stay a warning
    do_cycle(S, -1, 0, 2, 0);
    check("R6 same-cycle trips", ocp2_shutdown, 0);
    // R8: trip in next cycle
    do_cycle(S, -1, 0, 1, 0);
    check("R8 shutdown", ocp2_shutdown, 1);
    repeat (2) do_cycle(S, -1, 0, 1, 0);
    check("R9 shutdown holds", ocp2_shutdown, 1);
    do_uvlo();
    do_reset();

    // random phase
    for (int c = 0; c < 400; c++) begin
      int off_len, glitch, ntr;
      bit lvl;
      off_len = S - 2 + int'($urandom % 6);
      glitch  = ($urandom % 3 == 0) ? int'($urandom % off_len) : -1;
      lvl     = ($urandom % 10) < 8;
      ntr     = ($urandom % 4 == 0) ? 1 + int'($urandom % 2) : 0;
      do_cycle(off_len, glitch, lvl, ntr, ($urandom % 16) == 0);
      if ($urandom % 20 == 0) do_uvlo();
      if (c % 60 == 59) do_reset();
    end

    do_reset();
    tick();
    check("R1 final cnt", ovp_cnt, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule